// File: doc/BRIEF.md
# Duty-Ratio Fault Monitor With Hysteresis

This block raises a shared fault line when a power stage misbehaves. Two recurring conditions, an output overcurrent and a PWM duty-limit overrange, are combined into one sample taken every clock. The clock is the PWM period tick. Samples are counted over a window whose length is set by an input. At the close of each window the count of bad samples is compared against two fractions of the window length. More than 8% sets the fault. Less than 2% clears it. A count between the two leaves the fault as it was, so short bursts near one limit do not make the line chatter.

A supply undervoltage input skips the counting altogether. It drives the fault line in the same cycle and also sets the held fault state. After undervoltage goes away, the line stays active until a later window closes with a bad-sample count under the 2% limit. The output enables an open-drain pull-down, so several monitors can share one active-low wire. A longer window filters out transients better, and a shorter window reacts sooner.

Top module: `dutyfault_monitor`

## Requirements
- R1: When a window of N samples closes with a hit count H such that H*25 > N*2 (more than 8%), the held fault state is set and `faultPullDn` reads 1 after that clock edge.
- R2: When a window closes with H*50 < N (less than 2%) and undervoltage is low, the held fault state is cleared and `faultPullDn` reads 0 after that edge.
- R3: `underVoltage` = 1 drives `faultPullDn` to 1 in the same cycle, without waiting for a clock edge. Each edge that sees it while out of reset also sets the held fault state, so the output stays 1 after undervoltage drops.
- R4: A window count that satisfies neither R1 nor R2 (for example exactly 8% or exactly 2%) leaves the held state unchanged. The held state never changes between window closes, except through undervoltage.
- R5: Overcurrent and overrange are ORed into a single hit per sample. A sample with both inputs high counts as one hit, and either input alone counts as one hit.
- R6: The effective window length is `windowLen`, raised to a floor of 64 when a smaller value is given. It is taken at reset and again at the start of each window.
- R7: While `rstN` is low, the sample position and hit count are cleared and the held state is 0. During reset, `faultPullDn` equals `underVoltage`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per PWM period (one sample per edge) |
| rstN | input | 1 | Synchronous reset, active low |
| overCurrent | input | 1 | Output overcurrent seen during this period |
| overRange | input | 1 | PWM duty limit reached during this period |
| underVoltage | input | 1 | Supply undervoltage, acts at once |
| windowLen | input | 16 | Requested window length in samples (floor 64) |
| faultPullDn | output | 1 | 1 enables the open-drain pull-down, so the shared fault wire reads low |

## Verification
The bench uses the default 16-bit length field and a floor of 64, and most scenarios run with a 100-sample window. With 100 samples both percentage limits fall exactly on whole hit counts: 8 versus 9 hits for setting, and 2 versus 1 hit for clearing. This puts the strict-inequality edges and the hold band between them within reach. Requested lengths of 10, 63 and 64 exercise the floor: a hit pattern that would trip a 10-sample window must not trip the clamped 64-sample one.

// File: rtl/dutyfault_pkg.sv
package dutyfault_pkg;
  // strobes from the window sequencer to the counting datapath
  typedef struct packed {
    logic hit;   // this sample carries a fault condition
    logic last;  // this sample closes the current window
  } strobe_t;
endpackage

// File: rtl/dutyfault_ctrl.sv
module dutyfault_ctrl
  import dutyfault_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             overCurrent,
  input  logic             overRange,
  input  logic [LEN_W-1:0] windowLen,
  output strobe_t          strobe,
  output logic [LEN_W-1:0] curLen
);
  localparam logic [LEN_W-1:0] FloorLen = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] samplePos;
  logic [LEN_W-1:0] clampedLen;

  assign clampedLen  = (windowLen < FloorLen) ? FloorLen : windowLen;
  assign strobe.hit  = overCurrent | overRange;
  assign strobe.last = (samplePos == curLen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      samplePos <= '0;
      curLen    <= clampedLen;
    end else if (strobe.last) begin
      samplePos <= '0;
      curLen    <= clampedLen;
    end else begin
      samplePos <= samplePos + LEN_W'(1);
    end
  end
endmodule

// File: rtl/dutyfault_dp.sv
module dutyfault_dp
  import dutyfault_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int SET_NUM = 2,
  parameter int SET_DEN = 25,
  parameter int CLR_NUM = 1,
  parameter int CLR_DEN = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [LEN_W-1:0] curLen,
  input  logic             underVoltage,
  output logic             faultLatch
);
  localparam int PROD_W = LEN_W + 8;

  logic [LEN_W-1:0]  hitCount;
  logic [LEN_W:0]    total;
  logic [PROD_W-1:0] totalSet, totalClr, lenSet, lenClr;
  logic              overSet, underClr;

  assign total    = {1'b0, hitCount} + (LEN_W+1)'(strobe.hit);
  assign totalSet = PROD_W'(total) * PROD_W'(SET_DEN);
  assign totalClr = PROD_W'(total) * PROD_W'(CLR_DEN);
  assign lenSet   = PROD_W'(curLen) * PROD_W'(SET_NUM);
  assign lenClr   = PROD_W'(curLen) * PROD_W'(CLR_NUM);
  assign overSet  = totalSet > lenSet;
  assign underClr = totalClr < lenClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount   <= '0;
      faultLatch <= 1'b0;
    end else begin
      if (strobe.last) hitCount <= '0;
      else             hitCount <= total[LEN_W-1:0];

      if (underVoltage)                 faultLatch <= 1'b1;
      else if (strobe.last && overSet)  faultLatch <= 1'b1;
      else if (strobe.last && underClr) faultLatch <= 1'b0;
    end
  end
endmodule

// File: rtl/dutyfault_monitor.sv
module dutyfault_monitor
  import dutyfault_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             overCurrent,
  input  logic             overRange,
  input  logic             underVoltage,
  input  logic [LEN_W-1:0] windowLen,
  output logic             faultPullDn
);
  strobe_t          strobe;
  logic [LEN_W-1:0] curLen;
  logic             faultLatch;

  dutyfault_ctrl #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .overCurrent(overCurrent), .overRange(overRange),
    .windowLen(windowLen), .strobe(strobe), .curLen(curLen)
  );

  dutyfault_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curLen(curLen),
    .underVoltage(underVoltage), .faultLatch(faultLatch)
  );

  // undervoltage bypasses the window entirely
  assign faultPullDn = faultLatch | underVoltage;
endmodule

// File: rtl/dutyfault_checker.sv
module dutyfault_checker #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             underVoltage,
  input logic             faultLatch,
  input logic             winLast,
  input logic [LEN_W-1:0] curLen
);
  assert_set_at_close_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatch) |-> ($past(winLast) || $past(underVoltage)));

  assert_clear_at_close_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatch) |-> ($past(winLast) && !$past(underVoltage)));

  assert_uv_latched_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(underVoltage) && $past(rstN)) |-> faultLatch);

  assert_hold_midwindow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!winLast && !underVoltage) |=> $stable(faultLatch));

  assert_len_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    curLen >= LEN_W'(MIN_LEN));
endmodule

bind dutyfault_monitor dutyfault_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .underVoltage(underVoltage), .faultLatch(faultLatch),
  .winLast(strobe.last), .curLen(curLen)
);

// File: tb/dutyfault_monitor_test.sv
module dutyfault_monitor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        overCurrent = 1'b0;
  logic        overRange = 1'b0;
  logic        underVoltage = 1'b0;
  logic [15:0] windowLen = 16'd100;
  logic        faultPullDn;
  int          nChecks = 0;
  int          nFails = 0;

  dutyfault_monitor uut (
    .clk(clk), .rstN(rstN), .overCurrent(overCurrent), .overRange(overRange),
    .underVoltage(underVoltage), .windowLen(windowLen), .faultPullDn(faultPullDn)
  );

  always #4 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic applyReset(input int len, input logic uv);
    @(negedge clk);
    rstN = 1'b0; windowLen = 16'(len); underVoltage = uv;
    overCurrent = 1'b0; overRange = 1'b0;
    repeat (3) @(negedge clk);
    check(faultPullDn, uv, "R7", "output during reset follows undervoltage");
    underVoltage = 1'b0;
    rstN = 1'b1;
  endtask

  // n samples, the first `hits` bad; both=1 raises both sources together
  task automatic runWindow(input int n, input int hits, input bit both);
    for (int i = 0; i < n; i++) begin
      if (i < hits) begin
        overCurrent = both ? 1'b1 : (i % 2 == 0);
        overRange   = both ? 1'b1 : (i % 2 == 1);
      end else begin
        overCurrent = 1'b0; overRange = 1'b0;
      end
      @(negedge clk);
    end
    overCurrent = 1'b0; overRange = 1'b0;
  endtask

  task automatic testReset();
    applyReset(100, 1'b1);
    applyReset(100, 1'b0);
    runWindow(100, 9, 1'b0);
    check(faultPullDn, 1'b1, "R1", "set before reset");
    applyReset(100, 1'b0);
    #1 check(faultPullDn, 1'b0, "R7", "held state cleared by reset");
  endtask

  task automatic testSetClear();
    applyReset(100, 1'b0);
    runWindow(100, 8, 1'b0);
    check(faultPullDn, 1'b0, "R4", "exactly 8% does not set");
    runWindow(100, 9, 1'b0);
    check(faultPullDn, 1'b1, "R1", "9% sets");
    runWindow(50, 0, 1'b0);
    check(faultPullDn, 1'b1, "R4", "no change mid-window");
    runWindow(50, 0, 1'b0);
    check(faultPullDn, 1'b0, "R2", "0% clears");
    runWindow(100, 20, 1'b0);
    check(faultPullDn, 1'b1, "R1", "20% sets");
    runWindow(100, 4, 1'b0);
    check(faultPullDn, 1'b1, "R4", "4% holds set");
    runWindow(100, 2, 1'b0);
    check(faultPullDn, 1'b1, "R4", "exactly 2% holds set");
    runWindow(100, 1, 1'b0);
    check(faultPullDn, 1'b0, "R2", "1% clears");
  endtask

  task automatic testMerge();
    applyReset(100, 1'b0);
    runWindow(100, 5, 1'b1);
    check(faultPullDn, 1'b0, "R5", "both sources high count once");
    runWindow(100, 9, 1'b0);
    check(faultPullDn, 1'b1, "R5", "either source alone counts");
  endtask

  task automatic testUnderVoltage();
    applyReset(100, 1'b0);
    runWindow(20, 0, 1'b0);
    underVoltage = 1'b1;
    #1 check(faultPullDn, 1'b1, "R3", "undervoltage acts without a clock edge");
    runWindow(3, 0, 1'b0);
    underVoltage = 1'b0;
    #1 check(faultPullDn, 1'b1, "R3", "held after undervoltage drops");
    runWindow(76, 0, 1'b0);
    check(faultPullDn, 1'b1, "R3", "held until window close");
    runWindow(1, 0, 1'b0);
    check(faultPullDn, 1'b0, "R2", "clean window clears after undervoltage");
  endtask

  task automatic testFloor();
    applyReset(10, 1'b0);
    runWindow(10, 6, 1'b0);
    check(faultPullDn, 1'b0, "R6", "no close after 10 samples");
    runWindow(54, 0, 1'b0);
    check(faultPullDn, 1'b1, "R6", "close after 64 samples, 6 hits set");
    applyReset(63, 1'b0);
    runWindow(64, 5, 1'b0);
    check(faultPullDn, 1'b0, "R6", "63 raised to 64, 5 hits below 8%");
    applyReset(64, 1'b0);
    runWindow(64, 6, 1'b0);
    check(faultPullDn, 1'b1, "R6", "64 window, 6 hits set");
  endtask

  initial begin
    testReset();
    testSetClear();
    testMerge();
    testUnderVoltage();
    testFloor();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule